// File: doc/BRIEF.md
# Transmit Completion Log with Batched Interrupt

This block keeps a record of finished transmit descriptors and tells software about them in batches instead of once per packet. The descriptor walker hands over one completion at a time as a ring select bit plus a 12-bit descriptor index. Completions come in whatever order the priority scheduler released the descriptors. Each accepted completion is packed into a 32-bit log word and written into a circular buffer of parameterised depth.

The block keeps a count of entries that software has not yet acknowledged. It raises a level interrupt when that count reaches a programmable threshold. Software reads the oldest entry from the head port, recycles the descriptor it names, and pulses the acknowledge input. Each pulse moves the read pointer forward and lowers the count. A full buffer holds off the walker through a ready signal.

Top module: `txdone_coalescer`

## Requirements
- R1: A log word carries the descriptor index in bits 11:0 and the ring select in bit 15. Every other bit is zero.
- R2: The head port presents entries in the order they were accepted, whatever their index values.
- R3: The pending count rises by one for each accepted completion (`cmpl_valid` and `cmpl_ready` both high at a clock edge). It falls by one for each acknowledge taken while the count is non-zero.
- R4: When a completion is accepted and an acknowledge is taken at the same edge, the pending count stays the same, and both the write and read sides advance.
- R5: When the pending count equals DEPTH, `cmpl_ready` is low, and a completion presented then is not logged.
- R6: An acknowledge while the pending count is zero has no effect on the count or the pointers.
- R7: `irq` is high exactly when the threshold is non-zero and the pending count is at or above it. It drops once acknowledges bring the count below the threshold.
- R8: A threshold of zero keeps `irq` low for any pending count.
- R9: The write and read pointers wrap at DEPTH, so order is kept across more than DEPTH completions.
- R10: After reset the pending count is zero, `irq` and `head_valid` are low, and `cmpl_ready` is high. `head_valid` is high whenever the count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | Walker presents a completion |
| cmpl_ready | output | 1 | Log has room for a completion |
| cmpl_ring | input | 1 | Transmit ring of the completed descriptor |
| cmpl_idx | input | 12 | Index of the completed descriptor |
| irq_thresh | input | CNT_W (5) | Pending count that raises the interrupt; 0 disables it |
| ack | input | 1 | Software consumed the head entry |
| head_valid | output | 1 | At least one entry is pending |
| head_entry | output | 32 | Oldest pending log word |
| pending | output | CNT_W (5) | Number of unacknowledged entries |
| irq | output | 1 | Batched completion interrupt (level) |

## Verification
The hardest case to reach is a full log that receives a completion and an acknowledge in the same cycle. This only happens after the write pointer has already wrapped. The stimulus first partly drains the log so the pointers sit mid-buffer. It then refills the log to DEPTH and overlaps one push with one acknowledge at that boundary. After that it presents a completion while the log is full and drains everything. The scoreboard confirms that the rejected item never shows up and that the order of the rest survives the wrap.

// File: rtl/txdone_pkg.sv
package txdone_pkg;
    localparam int IDX_W    = 12;
    localparam int RING_BIT = 15;
    localparam int ENTRY_W  = 32;

    typedef logic [ENTRY_W-1:0] entry_t;

    function automatic entry_t pack_entry(input logic ring, input logic [IDX_W-1:0] idx);
        entry_t e;
        e = '0;
        e[IDX_W-1:0] = idx;
        e[RING_BIT]  = ring;
        return e;
    endfunction
endpackage

// File: rtl/tdc_store.sv
module tdc_store
    import txdone_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  entry_t           wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output entry_t           rd_data
);
    entry_t mem_q [DEPTH];
    entry_t mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_ptr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_ptr];
endmodule

// File: rtl/tdc_ptrs.sv
module tdc_ptrs #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             room,
    output logic             wr_fire,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    ptr_state_t st_q, st_d;
    logic       rd_fire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        room    = (st_q.cnt != FULL);
        wr_fire = push && room;
        rd_fire = pop && (st_q.cnt != '0);
        if (wr_fire) begin
            st_d.wr = bump(st_q.wr);
        end
        if (rd_fire) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({wr_fire, rd_fire})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign count  = st_q.cnt;
endmodule

// File: rtl/tdc_irq.sv
module tdc_irq #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    output logic             irq
);
    logic armed;

    always_comb begin
        armed = (thresh != '0);
        irq   = armed && (count >= thresh);
    end
endmodule

// File: rtl/txdone_coalescer.sv
module txdone_coalescer
    import txdone_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl_valid,
    output logic             cmpl_ready,
    input  logic             cmpl_ring,
    input  logic [11:0]      cmpl_idx,
    input  logic [CNT_W-1:0] irq_thresh,
    input  logic             ack,
    output logic             head_valid,
    output logic [31:0]      head_entry,
    output logic [CNT_W-1:0] pending,
    output logic             irq
);
    logic             wr_fire;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    entry_t           wr_word;

    assign wr_word = pack_entry(cmpl_ring, cmpl_idx);

    tdc_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (cmpl_valid),
        .pop     (ack),
        .room    (cmpl_ready),
        .wr_fire (wr_fire),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (pending)
    );

    tdc_store #(.DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_word),
        .rd_ptr  (rd_ptr),
        .rd_data (head_entry)
    );

    tdc_irq #(.CNT_W(CNT_W)) i_irq (
        .count  (pending),
        .thresh (irq_thresh),
        .irq    (irq)
    );

    assign head_valid = (pending != '0);
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmpl_valid,
    input logic             cmpl_ready,
    input logic             ack,
    input logic [CNT_W-1:0] irq_thresh,
    input logic             head_valid,
    input logic [31:0]      head_entry,
    input logic [CNT_W-1:0] pending,
    input logic             irq
);
    logic acc_w, acc_a;
    assign acc_w = cmpl_valid && cmpl_ready;
    assign acc_a = ack && (pending != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= CNT_W'(DEPTH)); // R5
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == CNT_W'(DEPTH)) |-> !cmpl_ready); // R5
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_w && !acc_a) |=> (pending == $past(pending) + 1'b1)); // R3
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_w && acc_a) |=> (pending == $past(pending) - 1'b1)); // R3
    AST_COUNT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_w && acc_a) |=> $stable(pending)); // R4
    AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pending == '0 && !cmpl_valid) |=> (pending == '0)); // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((irq_thresh != '0) && (pending >= irq_thresh))); // R7
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_thresh == '0) |-> !irq); // R8
    AST_HEAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid == (pending != '0)); // R10
    AST_ENTRY_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |-> (head_entry[31:16] == '0 && head_entry[14:12] == '0)); // R1
endmodule

bind txdone_coalescer tdc_checker #(.DEPTH(DEPTH)) i_tdc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmpl_valid (cmpl_valid),
    .cmpl_ready (cmpl_ready),
    .ack        (ack),
    .irq_thresh (irq_thresh),
    .head_valid (head_valid),
    .head_entry (head_entry),
    .pending    (pending),
    .irq        (irq)
);

// File: tb/test_txdone_coalescer.sv
module test_txdone_coalescer;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmpl_valid = 1'b0;
    logic             cmpl_ready;
    logic             cmpl_ring = 1'b0;
    logic [11:0]      cmpl_idx = '0;
    logic [CNT_W-1:0] irq_thresh = '0;
    logic             ack = 1'b0;
    logic             head_valid;
    logic [31:0]      head_entry;
    logic [CNT_W-1:0] pending;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q [$];

    always #4 clk = ~clk;

    txdone_coalescer #(.DEPTH(DEPTH)) i_txdone_coalescer (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every taken acknowledge consumes the head; compare it with the scoreboard (R2, R9)
    always @(negedge clk) begin
        if (rst_n && ack && head_valid) begin
            if (exp_q.size() == 0) begin
                check("R2", head_entry, 32'hFFFF_FFFF);
            end else begin
                check("R2", head_entry, exp_q.pop_front());
            end
        end
    end

    // Driver: one cycle, optional completion and optional acknowledge
    task automatic step(input logic v, input logic ring, input logic [11:0] idx, input logic a);
        @(posedge clk);
        #1;
        cmpl_valid = v;
        cmpl_ring  = ring;
        cmpl_idx   = idx;
        ack        = a;
        if (v && cmpl_ready) exp_q.push_back({16'h0, ring, 3'b000, idx});
        @(posedge clk);
        #1;
        cmpl_valid = 1'b0;
        ack        = 1'b0;
    endtask

    task automatic push(input logic ring, input logic [11:0] idx);
        step(1'b1, ring, idx, 1'b0);
    endtask

    task automatic pop1();
        step(1'b0, 1'b0, 12'h0, 1'b1);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10", {31'h0, head_valid}, 32'h0);
        check("R10", 32'(pending), 32'h0);
        check("R10", {31'h0, irq}, 32'h0);
        check("R10", {31'h0, cmpl_ready}, 32'h1);
        rst_n = 1'b1;
        irq_thresh = CNT_W'(4);

        // R1 field placement
        push(1'b1, 12'hABC);
        check("R1", head_entry, 32'h0000_8ABC);
        check("R10", {31'h0, head_valid}, 32'h1);
        push(1'b0, 12'h005);
        push(1'b1, 12'h7F0);
        check("R3", 32'(pending), 32'd3);
        check("R7", {31'h0, irq}, 32'h0);
        push(1'b0, 12'hFFF);
        check("R7", {31'h0, irq}, 32'h1);
        pop1();
        check("R3", 32'(pending), 32'd3);
        check("R7", {31'h0, irq}, 32'h0);
        // R4 simultaneous push and acknowledge
        step(1'b1, 1'b1, 12'h123, 1'b1);
        check("R4", 32'(pending), 32'd3);
        // R8 threshold zero disables
        irq_thresh = '0;
        for (int i = 0; i < 4; i++) push(i[0], 12'(i * 37));
        check("R8", 32'(pending), 32'd7);
        check("R8", {31'h0, irq}, 32'h0);
        irq_thresh = CNT_W'(DEPTH);
        // Fill to full (pointers already mid-buffer, so wrap occurs) R9
        for (int i = 0; i < DEPTH - 7; i++) push(1'b0, 12'(12'h400 + i));
        check("R5", 32'(pending), DEPTH);
        check("R5", {31'h0, cmpl_ready}, 32'h0);
        check("R7", {31'h0, irq}, 32'h1);
        // Full plus simultaneous ack: push rejected, pop taken
        step(1'b1, 1'b1, 12'hEEE, 1'b1);
        check("R5", 32'(pending), DEPTH - 1);
        // Completion while not full refills, then one while full is dropped
        push(1'b1, 12'h321);
        push(1'b1, 12'hBAD);
        check("R5", 32'(pending), DEPTH);
        // Drain all (R2, R9 order across wrap)
        for (int i = 0; i < DEPTH; i++) pop1();
        check("R3", 32'(pending), 32'd0);
        check("R9", exp_q.size(), 32'd0);
        // R6 acknowledge when empty
        pop1();
        check("R6", 32'(pending), 32'd0);
        push(1'b0, 12'h0AA);
        check("R6", head_entry, 32'h0000_00AA);
        pop1();
        check("R10", {31'h0, head_valid}, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule